// File: doc/BRIEF.md
# AES3 Channel-Status and User Bit Extractor

This block sits behind a biphase-mark decoder on the recovered master clock. Each decoded subframe arrives as a one-cycle strobe with its preamble type, its channel-status bit and its user bit. The block counts frames inside the 192-frame channel-status block, anchored on the block-start preamble. It raises a block-start indicator for a fixed window near the head of each block. It shifts the channel-status and user bits out one per subframe, each step triggered by an edge of the word clock.

For the first five channel-status bytes of each channel, the block assembles the bits in a working store. Only a block that began on a block-start preamble and ran its full length without a sync fault is committed to a read buffer. The audio/non-audio flag is refreshed from the same committed data. A block-start preamble that arrives out of place makes the counter resynchronise to it and raises a sync-fault flag.

Top module: `aes3_cs_extract`

## Requirements
- R1: Preamble codes on `sf_pre` are 00 = block start (channel A of frame 0), 01 = channel A of any other frame, 10 = channel B. A block-start subframe sets the frame count to 0. Each later channel-A subframe advances it by one, modulo 192. Channel-A and channel-B subframes are ignored until the first block-start subframe has been seen.
- R2: A block-start subframe that arrives while synchronised with a frame count other than 191 sets `blk_err`. So does a channel-A subframe that arrives at count 191 in place of a block-start subframe. A block-start subframe that arrives at count 191 clears `blk_err`.
- R3: `blk_start` is high while the frame count is 2 through 17. It is a register clocked by `clk` and follows the count one cycle later, so it is high for exactly 16 frames.
- R4: `blk_start` is low for frames 18 through 191 and before the first block-start subframe.
- R5: After each rising or falling edge of `lrck`, `c_out` and `u_out` take the channel-status and user bits of the most recent subframe, within four clocks. Without an `lrck` edge they hold their value.
- R6: Buffer byte `rd_byte` of channel `rd_ch` (0 = A, 1 = B) holds the channel-status bits of frames 8*rd_byte to 8*rd_byte+7 of that channel, least significant bit first. `rd_data` shows the byte one clock after the address is applied.
- R7: The buffer changes only when the channel-B subframe of frame 191 completes a block that began with a block-start subframe and had no sync fault. A block cut short leaves the buffer as it was.
- R8: `nonaudio` equals channel-status bit 1 of channel A of the last committed block, where low means linear PCM. It changes only at a commit.
- R9: After synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered master clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_valid | input | 1 | One-cycle strobe per decoded subframe |
| sf_pre | input | 2 | Preamble type of the subframe |
| sf_cbit | input | 1 | Channel-status bit of the subframe |
| sf_ubit | input | 1 | User bit of the subframe |
| lrck | input | 1 | Word clock, asynchronous to clk |
| rd_ch | input | 1 | Buffer read channel |
| rd_byte | input | 3 | Buffer read byte index |
| blk_start | output | 1 | Block-start window indicator |
| blk_err | output | 1 | Block sync fault flag |
| c_out | output | 1 | Serial channel-status bit |
| u_out | output | 1 | Serial user bit |
| nonaudio | output | 1 | Non-PCM flag from committed status |
| rd_data | output | 8 | Buffer read data |

## Verification
The assertions assume that `sf_valid` is a single-cycle strobe, with at least one idle clock between subframes. They also assume that `lrck` toggles no faster than once per few clocks, so every edge survives the synchroniser. The stimulus drives each subframe as a one-clock strobe followed by idle clocks, and toggles `lrck` only after the strobe has dropped. Random channel-status and user bits fill whole blocks. Directed sequences insert an early block-start preamble and a missing one.

// File: rtl/aes3_cs_pkg.sv
package aes3_cs_pkg;
  typedef enum logic [1:0] {
    PRE_Z    = 2'b00,
    PRE_X    = 2'b01,
    PRE_Y    = 2'b10,
    PRE_NONE = 2'b11
  } pre_e;
endpackage

// File: rtl/aes3_frame_tracker.sv
module aes3_frame_tracker
  import aes3_cs_pkg::*;
#(
  parameter int FRAMES    = 192,
  parameter int START_AT  = 2,
  parameter int START_LEN = 16,
  localparam int CW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sf_valid,
  input  logic [1:0]    sf_pre,
  output logic [CW-1:0] frame_cnt,
  output logic          synced,
  output logic          wr_en,
  output logic          wr_ch,
  output logic [CW-1:0] wr_idx,
  output logic          commit,
  output logic          blk_err,
  output logic          blk_start
);
  localparam logic [CW-1:0] LAST  = CW'(FRAMES - 1);
  localparam logic [CW-1:0] WIN_LO = CW'(START_AT);
  localparam logic [CW-1:0] WIN_HI = CW'(START_AT + START_LEN);

  pre_e pre;
  logic is_z, is_x, is_y;
  logic [CW-1:0] cnt_q;
  logic synced_q, good_q, err_q, start_q, commit_q;

  assign pre  = pre_e'(sf_pre);
  assign is_z = sf_valid && (pre == PRE_Z);
  assign is_x = sf_valid && (pre == PRE_X);
  assign is_y = sf_valid && (pre == PRE_Y);

  // frame index that the current subframe belongs to
  always_comb begin
    wr_en  = is_z || ((is_x || is_y) && synced_q);
    wr_ch  = is_y;
    if (is_z)
      wr_idx = '0;
    else if (is_x)
      wr_idx = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    else
      wr_idx = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      synced_q <= 1'b0;
      good_q   <= 1'b0;
      err_q    <= 1'b0;
      start_q  <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= is_y && synced_q && good_q && (cnt_q == LAST);
      start_q  <= synced_q && (cnt_q >= WIN_LO) && (cnt_q < WIN_HI);
      if (is_z) begin
        if (synced_q) err_q <= (cnt_q != LAST);
        cnt_q    <= '0;
        synced_q <= 1'b1;
        good_q   <= 1'b1;
      end else if (is_x && synced_q) begin
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          good_q <= 1'b0;
          err_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign frame_cnt = cnt_q;
  assign synced    = synced_q;
  assign commit    = commit_q;
  assign blk_err   = err_q;
  assign blk_start = start_q;
endmodule

// File: rtl/aes3_cs_collector.sv
module aes3_cs_collector #(
  parameter int CS_BYTES = 5,
  parameter int IDXW     = 8,
  localparam int NCH     = 2,
  localparam int CS_BITS = CS_BYTES * 8,
  localparam int CBW     = $clog2(CS_BITS),
  localparam int DEPTH   = NCH * CS_BYTES,
  localparam int AW      = $clog2(DEPTH),
  localparam int BW      = $clog2(CS_BYTES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_ch,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            cbit,
  input  logic            commit,
  input  logic            rd_ch,
  input  logic [BW-1:0]   rd_byte,
  output logic [7:0]      rd_data,
  output logic            nonaudio
);
  localparam logic [IDXW-1:0] IDX_LIM = IDXW'(CS_BITS);
  localparam logic [AW-1:0]   A_LIM   = AW'(DEPTH);
  localparam logic [AW-1:0]   A_STEP  = AW'(CS_BYTES);

  logic [CS_BITS-1:0] work_q [NCH];
  logic [7:0]         mem_q  [DEPTH];
  logic [AW-1:0]      rd_addr;
  logic [7:0]         rd_q;
  logic               na_q;

  // per-channel working store, bit k = status bit of frame k
  for (genvar ch = 0; ch < NCH; ch++) begin : g_work
    always_ff @(posedge clk) begin
      if (rst)
        work_q[ch] <= '0;
      else if (wr_en && (wr_ch == 1'(ch)) && (wr_idx < IDX_LIM))
        work_q[ch][wr_idx[CBW-1:0]] <= cbit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      na_q <= 1'b0;
    end else if (commit) begin
      for (int c = 0; c < NCH; c++)
        for (int b = 0; b < CS_BYTES; b++)
          mem_q[c*CS_BYTES + b] <= work_q[c][8*b +: 8];
      na_q <= work_q[0][1];
    end
  end

  assign rd_addr = (rd_ch ? A_STEP : '0) + AW'(rd_byte);

  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else
      rd_q <= (rd_addr < A_LIM) ? mem_q[rd_addr] : '0;
  end

  assign rd_data  = rd_q;
  assign nonaudio = na_q;
endmodule

// File: rtl/aes3_cu_serializer.sv
module aes3_cu_serializer #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lrck,
  input  logic sf_valid,
  input  logic cbit,
  input  logic ubit,
  output logic c_out,
  output logic u_out,
  output logic lr_edge
);
  logic [SYNC:0] lr_q;
  logic hold_c, hold_u, c_q, u_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_q   <= '0;
      hold_c <= 1'b0;
      hold_u <= 1'b0;
      c_q    <= 1'b0;
      u_q    <= 1'b0;
    end else begin
      lr_q <= {lr_q[SYNC-1:0], lrck};
      if (sf_valid) begin
        hold_c <= cbit;
        hold_u <= ubit;
      end
      if (lr_edge) begin
        c_q <= hold_c;
        u_q <= hold_u;
      end
    end
  end

  assign lr_edge = lr_q[SYNC] ^ lr_q[SYNC-1];
  assign c_out   = c_q;
  assign u_out   = u_q;
endmodule

// File: rtl/aes3_cs_extract.sv
module aes3_cs_extract #(
  parameter int FRAMES    = 192,
  parameter int START_AT  = 2,
  parameter int START_LEN = 16,
  parameter int CS_BYTES  = 5,
  parameter int LR_SYNC   = 2,
  localparam int CW = $clog2(FRAMES),
  localparam int BW = $clog2(CS_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sf_valid,
  input  logic [1:0]    sf_pre,
  input  logic          sf_cbit,
  input  logic          sf_ubit,
  input  logic          lrck,
  input  logic          rd_ch,
  input  logic [BW-1:0] rd_byte,
  output logic          blk_start,
  output logic          blk_err,
  output logic          c_out,
  output logic          u_out,
  output logic          nonaudio,
  output logic [7:0]    rd_data
);
  logic [CW-1:0] frame_cnt;
  logic          synced, wr_en, wr_ch, commit, lr_edge;
  logic [CW-1:0] wr_idx;

  aes3_frame_tracker #(
    .FRAMES(FRAMES), .START_AT(START_AT), .START_LEN(START_LEN)
  ) u_track (
    .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_pre(sf_pre),
    .frame_cnt(frame_cnt), .synced(synced), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_idx(wr_idx), .commit(commit), .blk_err(blk_err), .blk_start(blk_start)
  );

  aes3_cs_collector #(
    .CS_BYTES(CS_BYTES), .IDXW(CW)
  ) u_coll (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_idx(wr_idx),
    .cbit(sf_cbit), .commit(commit), .rd_ch(rd_ch), .rd_byte(rd_byte),
    .rd_data(rd_data), .nonaudio(nonaudio)
  );

  aes3_cu_serializer #(
    .SYNC(LR_SYNC)
  ) u_ser (
    .clk(clk), .rst(rst), .lrck(lrck), .sf_valid(sf_valid),
    .cbit(sf_cbit), .ubit(sf_ubit), .c_out(c_out), .u_out(u_out),
    .lr_edge(lr_edge)
  );
endmodule

// File: rtl/aes3_cs_extract_chk.sv
module aes3_cs_extract_chk #(
  parameter int FRAMES    = 192,
  parameter int START_AT  = 2,
  parameter int START_LEN = 16,
  localparam int CW = $clog2(FRAMES)
) (
  input logic          clk,
  input logic          rst,
  input logic          sf_valid,
  input logic [1:0]    sf_pre,
  input logic [CW-1:0] frame_cnt,
  input logic          synced,
  input logic          blk_start,
  input logic          blk_err,
  input logic          commit,
  input logic          nonaudio,
  input logic          lr_edge,
  input logic          c_out,
  input logic          u_out
);
  localparam logic [CW-1:0] LAST   = CW'(FRAMES - 1);
  localparam logic [CW-1:0] WIN_LO = CW'(START_AT);
  localparam logic [CW-1:0] WIN_HI = CW'(START_AT + START_LEN);

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    frame_cnt <= LAST);

  p_z_frame0_r1: assert property (@(posedge clk) disable iff (rst)
    (sf_valid && sf_pre == 2'b00) |=> (frame_cnt == '0 && synced));

  p_early_z_err_r2: assert property (@(posedge clk) disable iff (rst)
    (sf_valid && sf_pre == 2'b00 && synced && frame_cnt != LAST) |=> blk_err);

  p_start_window_r3: assert property (@(posedge clk) disable iff (rst)
    blk_start |-> ($past(synced) && $past(frame_cnt) >= WIN_LO && $past(frame_cnt) < WIN_HI));

  p_cu_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !lr_edge |=> ($stable(c_out) && $stable(u_out)));

  p_commit_full_r7: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(frame_cnt) == LAST);

  p_flag_on_commit_r8: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(nonaudio));
endmodule

bind aes3_cs_extract aes3_cs_extract_chk #(
  .FRAMES(FRAMES), .START_AT(START_AT), .START_LEN(START_LEN)
) u_chk (
  .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_pre(sf_pre),
  .frame_cnt(frame_cnt), .synced(synced), .blk_start(blk_start),
  .blk_err(blk_err), .commit(commit), .nonaudio(nonaudio),
  .lr_edge(lr_edge), .c_out(c_out), .u_out(u_out)
);

// File: tb/tb_aes3_cs_extract.sv
module tb_aes3_cs_extract;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sf_valid = 1'b0;
  logic [1:0] sf_pre = 2'b11;
  logic       sf_cbit = 1'b0, sf_ubit = 1'b0;
  logic       lrck = 1'b0;
  logic       rd_ch = 1'b0;
  logic [2:0] rd_byte = '0;
  logic       blk_start, blk_err, c_out, u_out, nonaudio;
  logic [7:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [191:0] cur_a, cur_b, com_a, com_b;

  always #2.5 clk = ~clk;

  aes3_cs_extract dut (
    .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_pre(sf_pre),
    .sf_cbit(sf_cbit), .sf_ubit(sf_ubit), .lrck(lrck), .rd_ch(rd_ch),
    .rd_byte(rd_byte), .blk_start(blk_start), .blk_err(blk_err),
    .c_out(c_out), .u_out(u_out), .nonaudio(nonaudio), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [191:0] bits, input int b);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = bits[8*b + j];
    return r;
  endfunction

  task automatic send_sf(input logic [1:0] pre, input logic c, input logic u, input bit tog);
    @(negedge clk);
    sf_valid = 1'b1; sf_pre = pre; sf_cbit = c; sf_ubit = u;
    @(negedge clk);
    sf_valid = 1'b0;
    if (tog) lrck = ~lrck;
    repeat (5) @(negedge clk);
    if (tog) begin
      chk("R5 c_out", {7'd0, c_out}, {7'd0, c});
      chk("R5 u_out", {7'd0, u_out}, {7'd0, u});
    end
  endtask

  task automatic check_buf(input string tag);
    for (int ch = 0; ch < 2; ch++)
      for (int b = 0; b < 5; b++) begin
        @(negedge clk);
        rd_ch = ch[0]; rd_byte = b[2:0];
        @(negedge clk);
        chk(tag, rd_data, exp_byte(ch == 0 ? com_a : com_b, b));
      end
  endtask

  // exp_err: -1 skips the flag check after frame 0
  task automatic send_block(input int nframes, input logic na, input int exp_err);
    for (int f = 0; f < 192; f++) begin
      cur_a[f] = 1'($urandom % 2);
      cur_b[f] = 1'($urandom % 2);
    end
    cur_a[1] = na;
    for (int f = 0; f < nframes; f++) begin
      send_sf(f == 0 ? 2'b00 : 2'b01, cur_a[f], 1'($urandom % 2), 1'b1);
      if (f == 0 && exp_err >= 0)
        chk("R2 flag after block-start", {7'd0, blk_err}, 8'(exp_err));
      send_sf(2'b10, cur_b[f], 1'($urandom % 2), 1'b1);
      if (f >= 2 && f < 18)
        chk("R1/R3 window high", {7'd0, blk_start}, 8'd1);
      else
        chk("R1/R4 window low", {7'd0, blk_start}, 8'd0);
    end
    if (nframes == 192) begin
      com_a = cur_a;
      com_b = cur_b;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    com_a = '0; com_b = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 blk_start", {7'd0, blk_start}, 8'd0);
    chk("R9 blk_err", {7'd0, blk_err}, 8'd0);
    chk("R9 c_out", {7'd0, c_out}, 8'd0);
    chk("R9 u_out", {7'd0, u_out}, 8'd0);
    chk("R9 nonaudio", {7'd0, nonaudio}, 8'd0);
    chk("R9 rd_data", rd_data, 8'd0);

    // R5: a subframe without an lrck edge leaves the serial outputs alone
    send_sf(2'b01, 1'b1, 1'b1, 1'b0);
    chk("R5 hold c", {7'd0, c_out}, 8'd0);
    chk("R5 hold u", {7'd0, u_out}, 8'd0);
    // R1/R4: before sync, non-start subframes do nothing
    for (int i = 0; i < 6; i++) send_sf(2'b01, 1'b0, 1'b0, 1'b1);
    chk("R1 unsynced err", {7'd0, blk_err}, 8'd0);
    chk("R4 unsynced start", {7'd0, blk_start}, 8'd0);

    // block 1: clean, non-PCM
    send_block(192, 1'b1, 0);
    chk("R2 clean block", {7'd0, blk_err}, 8'd0);
    chk("R8 nonaudio set", {7'd0, nonaudio}, 8'd1);
    check_buf("R6 buffer block1");

    // block 2 cut short after 100 frames
    send_block(100, 1'b0, 0);
    check_buf("R7 buffer kept");
    chk("R7 nonaudio kept", {7'd0, nonaudio}, 8'd1);

    // block 3 starts with an early block-start subframe
    send_block(192, 1'b0, 1);
    chk("R2 flag held", {7'd0, blk_err}, 8'd1);
    chk("R8 nonaudio clear", {7'd0, nonaudio}, 8'd0);
    check_buf("R6 buffer block3");

    // block 4 starts on time, clearing the flag
    send_block(192, 1'b1, 0);
    chk("R8 nonaudio block4", {7'd0, nonaudio}, 8'd1);
    check_buf("R6 buffer block4");

    // missing block-start subframe at the wrap
    send_sf(2'b01, 1'b0, 1'b0, 1'b1);
    chk("R2 missing start", {7'd0, blk_err}, 8'd1);
    chk("R4 after wrap", {7'd0, blk_start}, 8'd0);
    send_sf(2'b10, 1'b1, 1'b0, 1'b1);
    check_buf("R7 no commit after fault");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule